// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block sits behind a host data port of a network controller. It gives the host sequential byte or halfword access to the controller's local buffer memory. A separate register block loads a starting remote address and a transfer byte count. After that, each read or write strobe on the data port does the following:

- performs one memory access at the running address;
- moves the address forward, folding it back to the receive ring start when it reaches the ring stop;
- reduces the count;
- flags completion when the count runs out.

The local memory is held inside the block and has two accessible areas. The first is a 32-byte identification PROM area at the bottom of the address space. Reset fills it from the station address, and the host may overwrite it afterwards. The second is a packet area whose base and size are parameters. Addresses outside both areas are unbacked.

A configuration input selects 8-bit or 16-bit transfers. Read data comes out of a register one cycle after the strobe.

Top module: `rdma_port_engine`

## Requirements
- R1: With `cfg_word_i` low, each accepted access moves one byte at `rem_addr_o`, adds 1 to the address and subtracts 1 from the count.
- R2: With `cfg_word_i` high, an access uses the address with bit 0 cleared and moves two bytes little-endian: data bits [7:0] go to or come from the even byte, and bits [15:8] the odd byte. The running address (not the cleared one) then advances by 2.
- R3: When the advanced address equals `ring_stop_i`, the address becomes `ring_start_i` instead.
- R4: When the count before an accepted access is at most the transfer size (1 or 2), the count becomes 0 and `done_o` is high for exactly the next cycle. Otherwise the count drops by the transfer size and `done_o` stays low.
- R5: A port write while the count is 0 has no effect: memory, address and count are unchanged and no `done_o` pulse occurs.
- R6: A port read while the count is 0 is still performed: the address advances, the count stays 0 and `done_o` pulses.
- R7: Only addresses below 32, or within [PKT_BASE, PKT_BASE+PKT_SIZE), are backed. A write elsewhere changes no memory. A read elsewhere returns 16'h00FF in 8-bit mode and 16'hFFFF in 16-bit mode. Address and count still advance in both cases.
- R8: After reset, PROM byte k equals image byte k/2 (integer division). Image bytes 0..5 are `station_addr_i` bytes, least significant first. Bytes 6..13 are 0x00, and bytes 14..15 are 0x57. The image is in place from the second rising edge after reset release.
- R9: `rdata_o` and `rdata_valid_o` change on the edge after an accepted read. `rdata_valid_o` is high for that one cycle. `rdata_o` holds its value until the next accepted read. An 8-bit read returns zero in bits [15:8].
- R10: `load_i` sets the address and count from `load_addr_i` and `load_cnt_i` and cancels any port access in the same cycle. A write strobe together with a read strobe performs only the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| station_addr_i | input | 48 | Station address used for the PROM image, byte 0 in bits [7:0] |
| cfg_word_i | input | 1 | 1 = 16-bit transfers, 0 = 8-bit transfers |
| ring_start_i | input | ADDR_W | Ring start byte address (wrap target) |
| ring_stop_i | input | ADDR_W | Ring stop byte address (wrap point) |
| load_i | input | 1 | Load the running address and count |
| load_addr_i | input | ADDR_W | Remote start address to load |
| load_cnt_i | input | CNT_W | Byte count to load |
| port_wr_i | input | 1 | Data port write strobe |
| port_rd_i | input | 1 | Data port read strobe |
| port_wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| rdata_valid_o | output | 1 | Read data updated this cycle |
| rem_addr_o | output | ADDR_W | Current remote address |
| rem_cnt_o | output | CNT_W | Remaining byte count |
| done_o | output | 1 | Transfer-complete pulse |

## Verification
Wrap-around and completion can land on the same access. The bench provokes this with a 16-bit write whose advance reaches the ring stop while the count equals the transfer size. After that access, three things must hold together: the address must read as the ring start, the count must be zero, and `done_o` must be high. A second collision also gets checked: a load with a write in the same cycle, where the load must win and memory must stay untouched. Read data is compared from a queue filled with values predicted from the requirements.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int STATION_W  = 48;
  localparam int PROM_BYTES = 32;

  function automatic logic [1:0] xfer_bytes(input logic wide);
    return wide ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/rdma_addr_ctrl.sv
module rdma_addr_ctrl #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [CNT_W-1:0]  load_cnt_i,
  input  logic              acc_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] ring_start_i,
  input  logic [ADDR_W-1:0] ring_stop_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              done_o
);
  import rdma_pkg::*;

  logic [ADDR_W-1:0] addr_q, addr_inc, addr_nxt;
  logic [CNT_W-1:0]  cnt_q, cnt_step;
  logic              done_q, last;

  assign cnt_step = CNT_W'(xfer_bytes(wide_i));
  assign addr_inc = addr_q + ADDR_W'(xfer_bytes(wide_i));
  assign addr_nxt = (addr_inc == ring_stop_i) ? ring_start_i : addr_inc;
  assign last     = (cnt_q <= cnt_step);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= acc_i && !load_i && last;
      if (load_i) begin
        addr_q <= load_addr_i;
        cnt_q  <= load_cnt_i;
      end else if (acc_i) begin
        addr_q <= addr_nxt;
        cnt_q  <= last ? '0 : cnt_q - cnt_step;
      end
    end
  end

  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;
  assign done_o = done_q;

  p_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (addr_o == $past(load_addr_i)) && (cnt_o == $past(load_cnt_i)));

  p_step8_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !load_i && !wide_i && cnt_o > CNT_W'(1) && (addr_o + ADDR_W'(1) != ring_stop_i))
    |=> (cnt_o == $past(cnt_o) - CNT_W'(1)) && (addr_o == $past(addr_o) + ADDR_W'(1)));

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !load_i && (addr_o + ADDR_W'(xfer_bytes(wide_i)) == ring_stop_i))
    |=> addr_o == $past(ring_start_i));

  p_done_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cnt_o == '0);
endmodule

// File: rtl/rdma_byte_mem.sv
module rdma_byte_mem #(
  parameter int ADDR_W   = 16,
  parameter int PKT_BASE = 16384,
  parameter int PKT_SIZE = 2048
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [rdma_pkg::STATION_W-1:0]  station_i,
  input  logic                            rd_i,
  input  logic                            wr_i,
  input  logic                            wide_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [15:0]                     wdata_i,
  output logic [15:0]                     rdata_o,
  output logic                            rvalid_o
);
  import rdma_pkg::*;

  localparam int PKT_AW  = $clog2(PKT_SIZE);
  localparam int PROM_AW = $clog2(PROM_BYTES);
  localparam logic [ADDR_W:0] PKT_LO  = (ADDR_W+1)'(PKT_BASE);
  localparam logic [ADDR_W:0] PKT_HI  = (ADDR_W+1)'(PKT_BASE + PKT_SIZE);
  localparam logic [ADDR_W:0] PROM_HI = (ADDR_W+1)'(PROM_BYTES);

  logic [7:0] prom_q [PROM_BYTES];
  logic [7:0] prom_img [PROM_BYTES];
  logic [7:0] pkt_q [PKT_SIZE];
  logic       init_q;

  // PROM image: each of 16 source bytes appears twice
  for (genvar g = 0; g < PROM_BYTES; g++) begin : g_img
    localparam int SRC = g / 2;
    if (SRC < 6) begin : g_sta
      assign prom_img[g] = station_i[8*SRC +: 8];
    end else if (SRC >= 14) begin : g_sig
      assign prom_img[g] = 8'h57;
    end else begin : g_zero
      assign prom_img[g] = 8'h00;
    end
  end

  logic [ADDR_W-1:0]  lo_a, lo_rel;
  logic               in_prom, in_pkt, ok;
  logic [PROM_AW-1:0] p_lo, p_hi;
  logic [PKT_AW-1:0]  k_lo, k_hi;
  logic [7:0]         lo_b, hi_b;
  logic [15:0]        rd_word;

  assign lo_a    = wide_i ? {addr_i[ADDR_W-1:1], 1'b0} : addr_i;
  assign in_prom = {1'b0, lo_a} < PROM_HI;
  assign in_pkt  = ({1'b0, lo_a} >= PKT_LO) && ({1'b0, lo_a} < PKT_HI);
  assign ok      = in_prom || in_pkt;
  assign lo_rel  = lo_a - PKT_LO[ADDR_W-1:0];
  assign p_lo    = lo_a[PROM_AW-1:0];
  assign p_hi    = {p_lo[PROM_AW-1:1], 1'b1};
  assign k_lo    = lo_rel[PKT_AW-1:0];
  assign k_hi    = {k_lo[PKT_AW-1:1], 1'b1};
  assign lo_b    = in_prom ? prom_q[p_lo] : pkt_q[k_lo];
  assign hi_b    = in_prom ? prom_q[p_hi] : pkt_q[k_hi];

  always_comb begin
    if (!ok)         rd_word = wide_i ? 16'hFFFF : 16'h00FF;
    else if (wide_i) rd_word = {hi_b, lo_b};
    else             rd_word = {8'h00, lo_b};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b1;
      for (int i = 0; i < PROM_BYTES; i++) prom_q[i] <= 8'h00;
    end else if (init_q) begin
      init_q <= 1'b0;
      for (int i = 0; i < PROM_BYTES; i++) prom_q[i] <= prom_img[i];
    end else if (wr_i && in_prom) begin
      prom_q[p_lo] <= wdata_i[7:0];
      if (wide_i) prom_q[p_hi] <= wdata_i[15:8];
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i && in_pkt) begin
      pkt_q[k_lo] <= wdata_i[7:0];
      if (wide_i) pkt_q[k_hi] <= wdata_i[15:8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= rd_word;
    end
  end

  p_unbacked_ones_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !ok) |=> rdata_o[7:0] == 8'hFF);

  p_rvalid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);

  p_rhold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o) && !rvalid_o);
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine #(
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 16,
  parameter int PKT_BASE = 16384,
  parameter int PKT_SIZE = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [47:0]       station_addr_i,
  input  logic              cfg_word_i,
  input  logic [ADDR_W-1:0] ring_start_i,
  input  logic [ADDR_W-1:0] ring_stop_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [CNT_W-1:0]  load_cnt_i,
  input  logic              port_wr_i,
  input  logic              port_rd_i,
  input  logic [15:0]       port_wdata_i,
  output logic [15:0]       rdata_o,
  output logic              rdata_valid_o,
  output logic [ADDR_W-1:0] rem_addr_o,
  output logic [CNT_W-1:0]  rem_cnt_o,
  output logic              done_o
);
  logic wr_go, rd_go;

  // load cancels access; write beats read; writes need a live count
  assign wr_go = port_wr_i && !load_i && (rem_cnt_o != '0);
  assign rd_go = port_rd_i && !port_wr_i && !load_i;

  rdma_addr_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .load_addr_i (load_addr_i),
    .load_cnt_i  (load_cnt_i),
    .acc_i       (wr_go || rd_go),
    .wide_i      (cfg_word_i),
    .ring_start_i(ring_start_i),
    .ring_stop_i (ring_stop_i),
    .addr_o      (rem_addr_o),
    .cnt_o       (rem_cnt_o),
    .done_o      (done_o)
  );

  rdma_byte_mem #(.ADDR_W(ADDR_W), .PKT_BASE(PKT_BASE), .PKT_SIZE(PKT_SIZE)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .station_i(station_addr_i),
    .rd_i     (rd_go),
    .wr_i     (wr_go),
    .wide_i   (cfg_word_i),
    .addr_i   (rem_addr_o),
    .wdata_i  (port_wdata_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rdata_valid_o)
  );

  p_wr_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_wr_i && !load_i && rem_cnt_o == '0)
    |=> $stable(rem_addr_o) && rem_cnt_o == '0 && !done_o);

  p_rd_at_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_rd_i && !port_wr_i && !load_i && rem_cnt_o == '0)
    |=> done_o && rem_cnt_o == '0);

  p_wr_over_rd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_wr_i && port_rd_i) |=> !rdata_valid_o);
endmodule

// File: tb/rdma_port_engine_tb_top.sv
module rdma_port_engine_tb_top;
  localparam int BASE = 16384;
  localparam int SIZE = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] station = 48'h665544332211;
  logic        wide = 1'b0;
  logic [15:0] r_start = 16'(BASE);
  logic [15:0] r_stop  = 16'(BASE + SIZE);
  logic        load = 1'b0;
  logic [15:0] l_addr = '0;
  logic [15:0] l_cnt = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rvalid;
  logic [15:0] raddr;
  logic [15:0] rcnt;
  logic        done;

  always #5 clk = ~clk;

  rdma_port_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .station_addr_i(station), .cfg_word_i(wide),
    .ring_start_i(r_start), .ring_stop_i(r_stop), .load_i(load),
    .load_addr_i(l_addr), .load_cnt_i(l_cnt), .port_wr_i(wr), .port_rd_i(rd),
    .port_wdata_i(wdata), .rdata_o(rdata), .rdata_valid_o(rvalid),
    .rem_addr_o(raddr), .rem_cnt_o(rcnt), .done_o(done)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0]  mm [int];
  logic [15:0] exp_q [$];
  string       tag_q [$];
  int          m_addr = 0;
  int          m_cnt = 0;
  logic [15:0] last_rd = '0;

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit backed(int a);
    return (a < 32) || (a >= BASE && a < BASE + SIZE);
  endfunction

  // monitor: pop expected read data as the design produces it
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        chk("R9 unexpected rvalid", 1, 0);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, int'(rdata), int'(e));
        last_rd = e;
      end
    end
  end

  task automatic do_load(int a, int c);
    @(negedge clk);
    load = 1'b1; l_addr = 16'(a); l_cnt = 16'(c);
    m_addr = a; m_cnt = c;
    @(negedge clk);
    load = 1'b0;
  endtask

  // driver: apply one strobe, update the model, then check address/count/done
  task automatic access(string tag, bit w, bit r, logic [15:0] d);
    int step, a;
    bit go_w, go_r, exp_done;
    @(negedge clk);
    wr = w; rd = r; wdata = d;
    step = wide ? 2 : 1;
    a = wide ? (m_addr & ~1) : m_addr;
    go_w = w && (m_cnt != 0);
    go_r = r && !w;
    exp_done = 1'b0;
    if (go_w && backed(a)) begin
      mm[a] = d[7:0];
      if (wide) mm[a+1] = d[15:8];
    end
    if (go_r) begin
      if (!backed(a)) exp_q.push_back(wide ? 16'hFFFF : 16'h00FF);
      else if (wide)  exp_q.push_back({mm[a+1], mm[a]});
      else            exp_q.push_back({8'h00, mm[a]});
      tag_q.push_back({tag, " rdata"});
    end
    if (go_w || go_r) begin
      m_addr = (m_addr + step) & 16'hFFFF;
      if (m_addr == int'(r_stop)) m_addr = int'(r_start);
      if (m_cnt <= step) begin m_cnt = 0; exp_done = 1'b1; end
      else m_cnt = m_cnt - step;
    end
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    chk({tag, " addr"}, int'(raddr), m_addr);
    chk({tag, " count"}, int'(rcnt), m_cnt);
    chk({tag, " done"}, int'(done), int'(exp_done));
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      automatic int s = i / 2;
      mm[i] = (s < 6) ? station[8*s +: 8] : ((s >= 14) ? 8'h57 : 8'h00);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("reset addr", int'(raddr), 0);
    chk("reset count", int'(rcnt), 0);
    chk("reset done", int'(done), 0);
    chk("R9 reset rvalid", int'(rvalid), 0);
    repeat (2) @(negedge clk);

    // R8 PROM image, 8-bit reads; R1 stepping
    do_load(0, 32);
    for (int i = 0; i < 32; i++) access("R8 prom", 0, 1, '0);

    // R2 16-bit read at odd address uses even pair
    wide = 1'b1;
    do_load(1, 4);
    access("R2 odd addr", 0, 1, '0);
    access("R2 second", 0, 1, '0);

    // R1 8-bit writes and read back
    wide = 1'b0;
    do_load(BASE + 4, 3);
    access("R1 wr", 1, 0, 16'h00A1);
    access("R1 wr", 1, 0, 16'h00B2);
    access("R4 wr last", 1, 0, 16'h00C3);
    do_load(BASE + 4, 3);
    for (int i = 0; i < 3; i++) access("R1 rd", 0, 1, '0);

    // R2 little-endian 16-bit write, read as bytes; R4 odd count with step 2
    wide = 1'b1;
    do_load(BASE + 32, 3);
    access("R2 wr16", 1, 0, 16'h1234);
    access("R4 cnt1", 1, 0, 16'h5678);
    wide = 1'b0;
    do_load(BASE + 32, 4);
    for (int i = 0; i < 4; i++) access("R2 bytes", 0, 1, '0);
    @(negedge clk);
    chk("R4 done one cycle", int'(done), 0);

    // R9 hold: a write leaves rdata alone
    do_load(BASE + 100, 2);
    access("R9 hold wr", 1, 0, 16'h0077);
    chk("R9 rdata held", int'(rdata), int'(last_rd));

    // R3 + R4: wrap and completion on the same access
    wide = 1'b1;
    r_stop = 16'(BASE + 16);
    do_load(BASE + 14, 2);
    access("R3 wrap+done", 1, 0, 16'hBEEF);
    chk("R3 wrapped", int'(raddr), BASE);
    r_stop = 16'(BASE + SIZE);
    wide = 1'b0;

    // R5 write at zero count ignored
    do_load(BASE + 4, 0);
    access("R5 wr at zero", 1, 0, 16'h00EE);
    do_load(BASE + 4, 1);
    access("R5 mem untouched", 0, 1, '0);

    // R6 read at zero count
    do_load(BASE + 5, 0);
    access("R6 rd at zero", 0, 1, '0);

    // R7 unbacked window
    do_load(16'h0100, 4);
    access("R7 wr drop", 1, 0, 16'h0099);
    do_load(16'h0100, 4);
    access("R7 rd8", 0, 1, '0);
    wide = 1'b1;
    access("R7 rd16", 0, 1, '0);
    wide = 1'b0;

    // R10 load with write: load wins
    @(negedge clk);
    load = 1'b1; l_addr = 16'(BASE + 6); l_cnt = 16'd5; wr = 1'b1; wdata = 16'h0011;
    m_addr = BASE + 6; m_cnt = 5;
    @(negedge clk);
    load = 1'b0; wr = 1'b0;
    chk("R10 load addr", int'(raddr), BASE + 6);
    chk("R10 load count", int'(rcnt), 5);
    chk("R10 load done", int'(done), 0);
    access("R10 mem untouched", 0, 1, '0);
    // R10 write beats read
    access("R10 wr over rd", 1, 1, 16'h00D4);
    chk("R10 no rvalid", int'(rvalid), 0);
    do_load(BASE + 7, 1);
    access("R10 wr landed", 0, 1, '0);

    repeat (3) @(negedge clk);
    chk("R9 queue drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule